// File: doc/BRIEF.md
# TDM Time-Slot Access Handler

This block attaches a set of access units to a two-line serial time-division bus: a downstream line and an upstream line. Both lines carry a frame of 32 slots of 8 bits each, shifted one bit per clock, most significant bit first, and aligned by a frame sync pulse. Each access unit can be pointed at any slot and told which line to transmit on. It then listens on the other line in the same slot. A host reaches every unit through a small register bus, so software can place a byte on the bus or pick one up at any slot position.

The block drives a line only while some enabled unit owns the current slot on that line. At all other times the line's output enable is low, so other devices can share the bus. Transmit bytes written by the host are double-buffered: a new byte goes out from the start of the next occurrence of the unit's slot. If two enabled units claim the same slot on the same line, the lower-numbered unit keeps the slot, and the unit that lost records the clash in its status register.

Top module: `tdm_slot_access`

## Requirements
- R1: After reset, the configuration register of unit i reads 0x20+i (slot i, port bit set, enable and swap clear). The transmit, receive and status registers read 0x00, and neither line's output enable is asserted.
- R2: The clock cycle in which fsync is high carries slot 0 bit 0. Each later cycle advances one bit, so slot k bit b falls 8k+b cycles after the sync. Without a further sync, the position wraps from slot 31 bit 7 to slot 0 bit 0, and a sync arriving mid-frame restarts the count at slot 0 bit 0.
- R3: The configuration register is laid out as bits [4:0] slot, bit 5 port, bit 6 enable, bit 7 swap. An enabled unit transmits its byte MSB first during its slot. It transmits on the upstream line when (port XOR swap) is 1 and on the downstream line when it is 0.
- R4: An enabled unit shifts in, MSB first, the line it does not transmit on during its slot. At the end of the slot it loads the byte into its receive register and sets status bit 0. Writing 1 to status bit 0 clears it; if a set and a clear happen in the same cycle, the set wins.
- R5: A unit with enable clear neither drives any line nor updates its receive register or receive flag.
- R6: Setting the swap bit exchanges a unit's transmit line and receive line relative to those selected by the port bit.
- R7: A host write to a unit's transmit register never changes a byte already being shifted out. The new byte is sent from bit 0 of the next occurrence of the unit's slot.
- R8: When several enabled units claim the same slot on the same line, the lowest-numbered one drives. Every other claimant sets its status bit 1, which stays set until 1 is written to that bit.
- R9: A line's output enable is high only during slots owned by an enabled unit transmitting on that line. While it is high, the line data equals the owning unit's bit.
- R10: Register address bits [3:2] select the unit and bits [1:0] select the register: 0 configuration, 1 transmit, 2 receive, 3 status. Reads are combinational from the current contents, and the receive register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bus bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync; high in the cycle of slot 0 bit 0 |
| dd_i | input | 1 | Sampled downstream line |
| du_i | input | 1 | Sampled upstream line |
| dd_o | output | 1 | Downstream line data |
| dd_oe | output | 1 | Downstream line output enable |
| du_o | output | 1 | Upstream line data |
| du_oe | output | 1 | Upstream line output enable |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The assertions assume that fsync, when it is used, is a single-cycle pulse, and that the line inputs are valid bits in every cycle. They also assume that register writes arrive as single-cycle strobes with a stable address. The stimulus meets these assumptions: it drives every input only at the falling clock edge, drives fresh random line bits in each cycle, and raises fsync for one cycle at a time. Configuration changes are applied while the affected slots are idle, so a retargeted unit never starts partway through a slot. The behavioural model follows every cycle, including a mid-frame resync, a free-running wrap, and a transmit write landing in the middle of a slot.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int NUM_SLOTS  = 32;
  localparam int BYTE_W     = 8;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int BIT_W      = $clog2(BYTE_W);
  localparam int FRAME_BITS = NUM_SLOTS * BYTE_W;
  localparam int POS_W      = $clog2(FRAME_BITS);

  typedef enum logic {LINE_DN = 1'b0, LINE_UP = 1'b1} line_e;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_TX   = 2'd1,
    REG_RX   = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              swap;
    logic              en;
    logic              port;
    logic [SLOT_W-1:0] slot;
  } cfg_t;

  // line a unit transmits on; it receives from the other one
  function automatic line_e tx_line_of(input logic port, input logic swap);
    return line_e'(port ^ swap);
  endfunction

  // bit sent in serial position idx, MSB leaves first
  function automatic logic serial_bit(input logic [BYTE_W-1:0] b,
                                      input logic [BIT_W-1:0]  idx);
    return b[(BYTE_W-1) - int'(idx)];
  endfunction
endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
  import tdm_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [BIT_W-1:0]  cur_bit
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_now;

  always_comb begin
    if (fsync)                                    pos_now = '0;
    else if (pos_q == POS_W'(FRAME_BITS - 1))     pos_now = '0;
    else                                          pos_now = pos_q + 1'b1;
  end

  assign cur_slot = pos_now[POS_W-1:BIT_W];
  assign cur_bit  = pos_now[BIT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= POS_W'(FRAME_BITS - 1);
    else        pos_q <= pos_now;
  end

  AST_BIT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bit == BIT_W'(BYTE_W - 1)) |=> (cur_bit == '0)) // R2
    else $error("bit position did not wrap to 0");

  AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> (cur_slot == '0 && cur_bit == '0)) // R2
    else $error("sync did not restart the frame");
endmodule

// File: rtl/tdm_access_unit.sv
module tdm_access_unit
  import tdm_slot_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_tx,
  input  logic              wr_stat,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [BIT_W-1:0]  cur_bit,
  input  logic              dd_in,
  input  logic              du_in,
  input  logic              lost,
  output logic              req,
  output line_e             tx_line,
  output logic              tx_bit,
  output logic [BYTE_W-1:0] cfg_rd,
  output logic [BYTE_W-1:0] tx_rd,
  output logic [BYTE_W-1:0] rx_rd,
  output logic [BYTE_W-1:0] stat_rd
);
  cfg_t              cfg_q;
  logic [BYTE_W-1:0] tx_hold, tx_act, rx_shift, rx_q;
  logic              rx_flag, conflict;
  logic              slot_first, slot_last, rx_in;
  logic [BYTE_W-1:0] rx_next;

  assign slot_first = (cur_bit == '0);
  assign slot_last  = (cur_bit == BIT_W'(BYTE_W - 1));
  assign req        = cfg_q.en && (cur_slot == cfg_q.slot);
  assign tx_line    = tx_line_of(cfg_q.port, cfg_q.swap);
  assign rx_in      = (tx_line == LINE_UP) ? dd_in : du_in;
  assign rx_next    = {rx_shift[BYTE_W-2:0], rx_in};
  // bit 0 reads the held byte directly: it is the one loaded at this edge
  assign tx_bit     = slot_first ? tx_hold[BYTE_W-1] : serial_bit(tx_act, cur_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{swap: 1'b0, en: 1'b0, port: 1'b1, slot: SLOT_W'(IDX)};
      tx_hold  <= '0;
      tx_act   <= '0;
      rx_shift <= '0;
      rx_q     <= '0;
      rx_flag  <= 1'b0;
      conflict <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q   <= cfg_t'(wdata);
      if (wr_tx)  tx_hold <= wdata;
      if (req && slot_first) tx_act <= tx_hold;
      if (req) rx_shift <= rx_next;
      if (req && slot_last) rx_q <= rx_next;
      if (wr_stat && wdata[0]) rx_flag <= 1'b0;
      if (req && slot_last)    rx_flag <= 1'b1;
      if (wr_stat && wdata[1]) conflict <= 1'b0;
      if (lost)                conflict <= 1'b1;
    end
  end

  assign cfg_rd  = cfg_q;
  assign tx_rd   = tx_hold;
  assign rx_rd   = rx_q;
  assign stat_rd = {{(BYTE_W-2){1'b0}}, conflict, rx_flag};

  AST_RX_AT_SLOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(slot_last)) // R4
    else $error("receive flag rose away from slot end");

  AST_IDLE_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |=> $stable(rx_q)) // R5
    else $error("disabled unit updated its receive byte");

  AST_TX_NOT_MIDSLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_first |=> $stable(tx_act)) // R7
    else $error("shifting byte changed inside a slot");

  AST_LOSS_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> conflict) // R8
    else $error("lost claim not recorded");
endmodule

// File: rtl/tdm_line_arbiter.sv
module tdm_line_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] claim,
  input  logic [N-1:0] bits,
  output logic [N-1:0] grant,
  output logic         oe,
  output logic         dout
);
  always_comb begin
    grant = '0;
    oe    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (claim[i] && !oe) begin
        grant[i] = 1'b1;
        oe       = 1'b1;
      end
    end
    dout = |(grant & bits);
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) // R8
    else $error("more than one unit owns a line");

  AST_UNIT0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    claim[0] |-> grant[0]) // R8
    else $error("lowest unit did not win");
endmodule

// File: rtl/tdm_slot_access.sv
module tdm_slot_access
  import tdm_slot_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = $clog2(NUM_UNITS) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              dd_i,
  input  logic              du_i,
  output logic              dd_o,
  output logic              dd_oe,
  output logic              du_o,
  output logic              du_oe,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata
);
  localparam int UNIT_W = ADDR_W - 2;

  logic [SLOT_W-1:0]    cur_slot;
  logic [BIT_W-1:0]     cur_bit;
  logic [NUM_UNITS-1:0] req, tx_bit, lost;
  line_e                tx_line [NUM_UNITS];
  logic [BYTE_W-1:0]    cfg_rd [NUM_UNITS];
  logic [BYTE_W-1:0]    tx_rd  [NUM_UNITS];
  logic [BYTE_W-1:0]    rx_rd  [NUM_UNITS];
  logic [BYTE_W-1:0]    st_rd  [NUM_UNITS];
  logic [NUM_UNITS-1:0] line_claim [2];
  logic [NUM_UNITS-1:0] line_grant [2];
  logic [1:0]           line_oe, line_dout;

  reg_sel_e    sel;
  logic [UNIT_W-1:0] unit_sel;
  assign sel      = reg_sel_e'(reg_addr[1:0]);
  assign unit_sel = reg_addr[ADDR_W-1:2];

  tdm_frame_counter u_frame (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .cur_slot(cur_slot), .cur_bit(cur_bit)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic hit;
    assign hit = reg_wr && (unit_sel == UNIT_W'(u));
    tdm_access_unit #(.IDX(u)) u_unit (
      .clk(clk), .rst_n(rst_n),
      .wr_cfg(hit && sel == REG_CFG),
      .wr_tx(hit && sel == REG_TX),
      .wr_stat(hit && sel == REG_STAT),
      .wdata(reg_wdata),
      .cur_slot(cur_slot), .cur_bit(cur_bit),
      .dd_in(dd_i), .du_in(du_i),
      .lost(lost[u]),
      .req(req[u]), .tx_line(tx_line[u]), .tx_bit(tx_bit[u]),
      .cfg_rd(cfg_rd[u]), .tx_rd(tx_rd[u]), .rx_rd(rx_rd[u]), .stat_rd(st_rd[u])
    );
    assign lost[u] = req[u] && !line_grant[tx_line[u]][u];
  end

  for (genvar l = 0; l < 2; l++) begin : g_line
    always_comb begin
      for (int u = 0; u < NUM_UNITS; u++)
        line_claim[l][u] = req[u] && (tx_line[u] == line_e'(l));
    end
    tdm_line_arbiter #(.N(NUM_UNITS)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .claim(line_claim[l]), .bits(tx_bit),
      .grant(line_grant[l]), .oe(line_oe[l]), .dout(line_dout[l])
    );
  end

  assign dd_oe = line_oe[LINE_DN];
  assign dd_o  = line_dout[LINE_DN];
  assign du_oe = line_oe[LINE_UP];
  assign du_o  = line_dout[LINE_UP];

  always_comb begin
    unique case (sel)
      REG_CFG:  reg_rdata = cfg_rd[unit_sel];
      REG_TX:   reg_rdata = tx_rd[unit_sel];
      REG_RX:   reg_rdata = rx_rd[unit_sel];
      default:  reg_rdata = st_rd[unit_sel];
    endcase
  end

  AST_DD_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> (|line_claim[LINE_DN])) // R9
    else $error("downstream driven with no owner");

  AST_DU_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    du_oe |-> (|line_claim[LINE_UP])) // R9
    else $error("upstream driven with no owner");
endmodule

// File: tb/tdm_slot_access_tb.sv
`timescale 1ns/1ps
module tdm_slot_access_tb;
  logic       clk = 1'b0;
  logic       rst_n, fsync, dd_i, du_i;
  logic       dd_o, dd_oe, du_o, du_oe;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  tdm_slot_access u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .dd_i(dd_i), .du_i(du_i),
    .dd_o(dd_o), .dd_oe(dd_oe), .du_o(du_o), .du_oe(du_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int    vectors = 0, fails = 0;
  string cur_req = "R1";
  bit    fs_on = 1'b1;
  logic [3:0] rd_rot = 4'd0;
  logic [7:0] last_rd;

  // behavioural model state
  logic [7:0] m_cfg [4], m_tx [4], m_act [4], m_sh [4], m_rx [4];
  bit         m_flag [4], m_conf [4];
  int         m_pos;

  function automatic logic [7:0] m_read(input logic [3:0] a);
    int u = int'(a[3:2]);
    case (a[1:0])
      2'd0: return m_cfg[u];
      2'd1: return m_tx[u];
      2'd2: return m_rx[u];
      default: return {6'b0, m_conf[u], m_flag[u]};
    endcase
  endfunction

  task automatic note(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit fs, input bit wr, input logic [3:0] a, input logic [7:0] d);
    int npos, slot, bt, wdn, wup;
    bit line [4];
    bit match [4];
    bit obit [4];
    bit rin;
    logic [7:0] nsh;
    @(negedge clk);
    fsync = fs; dd_i = 1'($urandom); du_i = 1'($urandom);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    npos = fs ? 0 : (m_pos + 1) % 256;
    slot = npos / 8; bt = npos % 8;
    wdn = -1; wup = -1;
    for (int i = 0; i < 4; i++) begin
      line[i]  = m_cfg[i][5] ^ m_cfg[i][7];
      match[i] = m_cfg[i][6] && (int'(m_cfg[i][4:0]) == slot);
      obit[i]  = (bt == 0) ? m_tx[i][7] : m_act[i][7-bt];
      if (match[i] && !line[i] && wdn < 0) wdn = i;
      if (match[i] &&  line[i] && wup < 0) wup = i;
    end
    note(cur_req, "dd_oe", {7'b0, dd_oe}, {7'b0, wdn >= 0});
    note(cur_req, "du_oe", {7'b0, du_oe}, {7'b0, wup >= 0});
    if (wdn >= 0) note(cur_req, "dd_o", {7'b0, dd_o}, {7'b0, obit[wdn]});
    if (wup >= 0) note(cur_req, "du_o", {7'b0, du_o}, {7'b0, obit[wup]});
    note("R10", "reg_rdata", reg_rdata, m_read(a));
    last_rd = reg_rdata;
    // state as it will be after the rising edge
    for (int i = 0; i < 4; i++) begin
      if (wr && a[3:2] == 2'(i) && a[1:0] == 2'd3) begin
        if (d[0]) m_flag[i] = 1'b0;
        if (d[1]) m_conf[i] = 1'b0;
      end
      if (match[i]) begin
        rin = line[i] ? dd_i : du_i;
        if (bt == 0) m_act[i] = m_tx[i];
        nsh = {m_sh[i][6:0], rin};
        m_sh[i] = nsh;
        if (bt == 7) begin m_rx[i] = nsh; m_flag[i] = 1'b1; end
        if (i != (line[i] ? wup : wdn)) m_conf[i] = 1'b1;
      end
    end
    if (wr && a[1:0] == 2'd0) m_cfg[a[3:2]] = d;
    if (wr && a[1:0] == 2'd1) m_tx[a[3:2]]  = d;
    m_pos = npos;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      step(fs_on && m_pos == 255, 1'b0, rd_rot, 8'h00);
      rd_rot = rd_rot + 4'd1;
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    step(fs_on && m_pos == 255, 1'b1, a, d);
  endtask

  task automatic check_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
    step(fs_on && m_pos == 255, 1'b0, a, 8'h00);
    note(tag, "register", last_rd, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] keep;
    rst_n = 1'b0; fsync = 1'b0; dd_i = 1'b0; du_i = 1'b0;
    reg_wr = 1'b0; reg_addr = 4'd0; reg_wdata = 8'h00;
    for (int i = 0; i < 4; i++) begin
      m_cfg[i] = 8'h20 | 8'(i); m_tx[i] = 0; m_act[i] = 0; m_sh[i] = 0; m_rx[i] = 0;
      m_flag[i] = 0; m_conf[i] = 0;
    end
    m_pos = 255;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: defaults, nothing driven
    cur_req = "R1";
    for (int i = 0; i < 4; i++) begin
      check_reg(4'(4*i),     8'h20 | 8'(i), "R1");
      check_reg(4'(4*i + 1), 8'h00, "R1");
      check_reg(4'(4*i + 2), 8'h00, "R1");
      check_reg(4'(4*i + 3), 8'h00, "R1");
    end
    cur_req = "R9";
    run(300);

    // R3/R4: unit0 slot0 upstream, unit1 slot5 downstream
    cur_req = "R3";
    wreg(4'h1, 8'hA5); wreg(4'h0, 8'h60);
    wreg(4'h5, 8'h3C); wreg(4'h4, 8'h45);
    run(600);
    cur_req = "R4";
    check_reg(4'h3, 8'h01, "R4");
    check_reg(4'h7, 8'h01, "R4");
    wreg(4'h3, 8'h01);
    check_reg(4'h3, 8'h00, "R4");
    run(300);

    // R7: transmit write lands at slot0 bit 3
    cur_req = "R7";
    while (m_pos != 2) run(1);
    wreg(4'h1, 8'h5A);
    run(520);

    // R6: unit3 slot 9, port up with swap so it sends downstream
    cur_req = "R6";
    wreg(4'hD, 8'hC3); wreg(4'hC, 8'hE9);
    run(520);

    // R8: unit2 claims slot 5 downstream beside unit1
    cur_req = "R8";
    wreg(4'h9, 8'hF0); wreg(4'h8, 8'h45);
    run(520);
    check_reg(4'hB, 8'h03, "R8");
    check_reg(4'h7, 8'h01, "R8");
    wreg(4'hB, 8'h02);
    wreg(4'h8, 8'h22);  // unit2 back to idle defaults
    check_reg(4'hB, 8'h01, "R8");

    // R5: disable unit0; its flag stays clear and the upstream line idles
    cur_req = "R5";
    wreg(4'h0, 8'h20); wreg(4'h3, 8'h01);
    run(600);
    check_reg(4'h3, 8'h00, "R5");

    // R10: receive register ignores writes
    check_reg(4'h2, m_rx[0], "R10");
    keep = last_rd;
    wreg(4'h2, ~keep);
    check_reg(4'h2, keep, "R10");

    // R2: resync mid-frame, then free-run across the wrap
    cur_req = "R2";
    while (m_pos != 99) run(1);
    step(1'b1, 1'b0, 4'h0, 8'h00);
    fs_on = 1'b0;
    run(700);
    fs_on = 1'b1;
    run(300);

    finish_run();
  end
endmodule